// File: doc/BRIEF.md
# Switchable-Depth Serial Receive Buffer

This block is the receive-side character store of a 16550-class serial controller. Received bytes arrive on a byte-wide input with a valid strobe, from either the deserializer or an internal loopback path. They leave through a read strobe that serves the receive data register. The block also owns the FIFO control register. A write to that register selects between a single-character legacy mode and a sixteen-entry queued mode. It can also flush the store.

The depth is decided at run time. Out of reset the store holds exactly one character. Software must set the enable bit of the control register before sixteen entries can be used. Whenever the enable bit changes state, the contents are discarded. The block reports the number of stored characters, full and empty flags, and a one-cycle overrun indication when a byte arrives with no room left.

Top module: `uart_rxb_top`

## Requirements
- R1: After synchronous reset the count is 0, the empty flag is 1, the full flag is 0, the overrun output is 0 and the control register reads 0x00.
- R2: While control bit 0 (enable) is 0, the store holds one character: the full flag is set at a count of 1.
- R3: A push while the count equals the current depth is discarded, and `overrun` is 1 during the single cycle that follows that clock edge.
- R4: A read request while the store is empty gives `pop_valid` = 0 and leaves the count unchanged.
- R5: A control write whose bit 0 differs from the stored bit 0 empties the store and sets the depth to 16 (bit 0 = 1) or 1 (bit 0 = 0). A push or read request in that same cycle is discarded.
- R6: A control write with bit 0 = 0 stores 0x00, whatever its other bits are, and does not empty the store unless bit 0 was previously 1.
- R7: A control write with bit 0 = 1 keeps only bit 0, bit 3 (DMA mode) and bits 7:6 (receive trigger), which is a keep mask of 0xC9. Bit 1 and bit 2 always read back 0.
- R8: A control write with bit 0 = 1 and bit 1 (receiver reset) = 1 empties the store, and the depth stays 16.
- R9: A push and a read request in the same cycle, when the store is neither full nor empty, leave the count unchanged and return the oldest character.
- R10: In queued mode, characters are returned in arrival order across pointer wrap-around, and the full flag is set at a count of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Received byte is present on push_data |
| push_data | input | 8 | Received byte |
| pop_req | input | 1 | Read strobe of the receive data register |
| pop_data | output | 8 | Oldest stored byte, meaningful while pop_valid is 1 |
| pop_valid | output | 1 | The read strobe in this cycle removes a byte |
| fcr_wr | input | 1 | Write strobe of the FIFO control register |
| fcr_wdata | input | 8 | Value written to the FIFO control register |
| fcr_q | output | 8 | Stored FIFO control register value |
| fill_count | output | 5 | Number of stored bytes |
| buf_empty | output | 1 | Count is zero |
| buf_full | output | 1 | Count equals the current depth |
| overrun | output | 1 | A byte was dropped at the previous clock edge |

## Verification
The properties check these every cycle: the one-entry limit in legacy mode, the overrun pulse after a push into a full store, the gating of reads from an empty store, control-register masking and zeroing, flushing on an enable change or a receiver reset, and the constant count under a simultaneous push and pop. Ordering of the data, wrap-around of the pointers and the exact bytes returned can only be shown by the bench scenarios. The same holds for the rule that a push in the same cycle as a flush is lost, and for the reset values after the store has been used.

// File: rtl/uart_rxb_pkg.sv
// Package: shared constants of the receive buffer. The bit positions of the
// control register are fixed by software and decoded by the control logic.
package uart_rxb_pkg;
    localparam int FCR_W        = 8;
    localparam int FCR_EN_BIT   = 0;
    localparam int FCR_RXRST_BIT = 1;
    localparam logic [FCR_W-1:0] FCR_KEEP_MASK = 8'hC9;
endpackage

// File: rtl/uart_rxb_fcr.sv
// Module: uart_rxb_fcr
// Decodes writes to the FIFO control register. It holds the stored value,
// raises a flush request for one cycle when the store must be emptied, and
// reports whether the deep (queued) mode is active.
// Assumes: fcr_wr is a single-cycle strobe qualified by the bus decoder.
module uart_rxb_fcr
    import uart_rxb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fcr_wr,
    input  logic [FCR_W-1:0] fcr_wdata,
    output logic [FCR_W-1:0] fcr_q,
    output logic             flush,
    output logic             deep
);
    logic en_new;
    logic en_change;

    // Purpose: work out whether this write empties the store.
    always_comb begin
        en_new    = fcr_wdata[FCR_EN_BIT];
        en_change = en_new ^ fcr_q[FCR_EN_BIT];
        flush     = fcr_wr && (en_change || (en_new && fcr_wdata[FCR_RXRST_BIT]));
    end

    // Purpose: hold the register value, zeroed when the enable bit is clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcr_q <= '0;
        end else if (fcr_wr) begin
            fcr_q <= en_new ? (fcr_wdata & FCR_KEEP_MASK) : '0;
        end
    end

    assign deep = fcr_q[FCR_EN_BIT];
endmodule

// File: rtl/uart_rxb_ptrs.sv
// Module: uart_rxb_ptrs
// Read/write pointers and the fill count. The pointers wrap at the current
// depth, which is either MAX_DEPTH or one. A flush has priority over
// push and pop in the same cycle.
// Assumes: depth changes only together with a flush.
module uart_rxb_ptrs #(
    parameter int MAX_DEPTH = 16,
    localparam int PTR_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
    localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             deep,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             pop_ok,
    output logic             overrun
);
    logic [CNT_W-1:0] depth_v;

    // Purpose: advance a pointer modulo the current depth.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                              input logic [CNT_W-1:0] d);
        logic [CNT_W-1:0] nxt;
        nxt = CNT_W'(p) + CNT_W'(1);
        return (nxt >= d) ? '0 : PTR_W'(nxt);
    endfunction

    // Purpose: derive depth, flags and qualified strobes.
    always_comb begin
        depth_v = deep ? CNT_W'(MAX_DEPTH) : CNT_W'(1);
        empty   = (count == '0);
        full    = (count >= depth_v);
        wr_en   = push_req && !full && !flush;
        pop_ok  = pop_req && !empty && !flush;
    end

    // Purpose: update pointers and count, or clear them on a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en)  wr_ptr <= bump(wr_ptr, depth_v);
            if (pop_ok) rd_ptr <= bump(rd_ptr, depth_v);
            if (wr_en && !pop_ok)      count <= count + CNT_W'(1);
            else if (pop_ok && !wr_en) count <= count - CNT_W'(1);
        end
    end

    // Purpose: flag a dropped byte for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else        overrun <= push_req && full && !flush;
    end
endmodule

// File: rtl/uart_rxb_mem.sv
// Module: uart_rxb_mem
// Register-file storage for the received bytes, with one write port and an
// asynchronous read port. Entries carry no reset.
// Assumes: wr_ptr and rd_ptr stay below MAX_DEPTH.
module uart_rxb_mem #(
    parameter int DATA_W    = 8,
    parameter int MAX_DEPTH = 16,
    localparam int PTR_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [MAX_DEPTH];

    for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_entry
        // Purpose: capture a byte into entry i.
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == PTR_W'(i)) mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/uart_rxb_top.sv
// Module: uart_rxb_top
// Receive character store with a run-time depth of 1 or MAX_DEPTH. It
// owns the FIFO control register and reports fill status and overrun.
// Assumes: a single clock domain; the source drives push_valid for one
// cycle per byte.
module uart_rxb_top
    import uart_rxb_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MAX_DEPTH = 16,
    localparam int PTR_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
    localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    input  logic              fcr_wr,
    input  logic [FCR_W-1:0]  fcr_wdata,
    output logic [FCR_W-1:0]  fcr_q,
    output logic [CNT_W-1:0]  fill_count,
    output logic              buf_empty,
    output logic              buf_full,
    output logic              overrun
);
    logic             flush;
    logic             deep;
    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    uart_rxb_fcr u_fcr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fcr_wr    (fcr_wr),
        .fcr_wdata (fcr_wdata),
        .fcr_q     (fcr_q),
        .flush     (flush),
        .deep      (deep)
    );

    uart_rxb_ptrs #(.MAX_DEPTH(MAX_DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .deep     (deep),
        .push_req (push_valid),
        .pop_req  (pop_req),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (fill_count),
        .empty    (buf_empty),
        .full     (buf_full),
        .pop_ok   (pop_valid),
        .overrun  (overrun)
    );

    uart_rxb_mem #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (push_data),
        .rd_ptr  (rd_ptr),
        .rd_data (pop_data)
    );
endmodule

// File: rtl/uart_rxb_chk.sv
// Module: uart_rxb_chk
// Port-level properties of the receive buffer, attached with bind.
module uart_rxb_chk #(
    parameter int DATA_W    = 8,
    parameter int MAX_DEPTH = 16,
    localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              pop_req,
    input logic              pop_valid,
    input logic              fcr_wr,
    input logic [7:0]        fcr_wdata,
    input logic [7:0]        fcr_q,
    input logic [CNT_W-1:0]  fill_count,
    input logic              buf_empty,
    input logic              buf_full,
    input logic              overrun
);
    p_legacy_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fcr_q[0] |-> fill_count <= CNT_W'(1));

    p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && buf_full && !fcr_wr |=> overrun);

    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && buf_empty |-> !pop_valid);

    p_flush_on_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && (fcr_wdata[0] != fcr_q[0]) |=> fill_count == '0);

    p_fcr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && !fcr_wdata[0] |=> fcr_q == 8'h00);

    p_fcr_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && fcr_wdata[0] |=> fcr_q == ($past(fcr_wdata) & 8'hC9));

    p_rx_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && fcr_wdata[0] && fcr_wdata[1] |=> fill_count == '0);

    p_push_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && pop_req && !buf_full && !buf_empty && !fcr_wr
        |=> $stable(fill_count));

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(MAX_DEPTH));
endmodule

bind uart_rxb_top uart_rxb_chk #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .pop_valid  (pop_valid),
    .fcr_wr     (fcr_wr),
    .fcr_wdata  (fcr_wdata),
    .fcr_q      (fcr_q),
    .fill_count (fill_count),
    .buf_empty  (buf_empty),
    .buf_full   (buf_full),
    .overrun    (overrun)
);

// File: tb/uart_rxb_top_tb_top.sv
module uart_rxb_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic       pop_valid;
    logic       fcr_wr = 1'b0;
    logic [7:0] fcr_wdata = '0;
    logic [7:0] fcr_q;
    logic [4:0] fill_count;
    logic       buf_empty;
    logic       buf_full;
    logic       overrun;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_rxb_top dut_i (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
        .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .fcr_q(fcr_q),
        .fill_count(fill_count), .buf_empty(buf_empty), .buf_full(buf_full),
        .overrun(overrun)
    );

    typedef struct packed {
        logic       fw;
        logic [7:0] fd;
        logic       pu;
        logic [7:0] pd;
        logic       po;
        logic       epv;
        logic [7:0] epd;
        logic [4:0] ecnt;
        logic [7:0] efcr;
        logic       eovr;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 1'b1, 8'hA1, 1'b0, 1'b0, 8'h00, 5'd1, 8'h00, 1'b0}, // R2 store one
        '{1'b0, 8'h00, 1'b1, 8'hB2, 1'b0, 1'b0, 8'h00, 5'd1, 8'h00, 1'b1}, // R3 dropped
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'hA1, 5'd0, 8'h00, 1'b0}, // R2 read
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 5'd0, 8'h00, 1'b0}, // R4 empty read
        '{1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 5'd1, 8'h00, 1'b0}, // R2
        '{1'b1, 8'hCF, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 5'd0, 8'hC9, 1'b0}, // R5 R7 enable
        '{1'b0, 8'h00, 1'b1, 8'h21, 1'b0, 1'b0, 8'h00, 5'd1, 8'hC9, 1'b0}, // R10
        '{1'b0, 8'h00, 1'b1, 8'h22, 1'b0, 1'b0, 8'h00, 5'd2, 8'hC9, 1'b0}, // R10
        '{1'b0, 8'h00, 1'b1, 8'h23, 1'b0, 1'b0, 8'h00, 5'd3, 8'hC9, 1'b0}, // R10
        '{1'b0, 8'h00, 1'b1, 8'h24, 1'b1, 1'b1, 8'h21, 5'd3, 8'hC9, 1'b0}, // R9
        '{1'b1, 8'hCB, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 5'd0, 8'hC9, 1'b0}, // R8 R7
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 5'd0, 8'hC9, 1'b0}, // R4 R8
        '{1'b0, 8'h00, 1'b1, 8'h31, 1'b0, 1'b0, 8'h00, 5'd1, 8'hC9, 1'b0}, // R10
        '{1'b1, 8'hFE, 1'b1, 8'h99, 1'b0, 1'b0, 8'h00, 5'd0, 8'h00, 1'b0}, // R5 R6 push lost
        '{1'b0, 8'h00, 1'b1, 8'h41, 1'b0, 1'b0, 8'h00, 5'd1, 8'h00, 1'b0}, // R2
        '{1'b0, 8'h00, 1'b1, 8'h42, 1'b1, 1'b1, 8'h41, 5'd0, 8'h00, 1'b1}, // R3 full push+pop
        '{1'b0, 8'h00, 1'b1, 8'h51, 1'b0, 1'b0, 8'h00, 5'd1, 8'h00, 1'b0}, // R2
        '{1'b1, 8'h08, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 5'd1, 8'h00, 1'b0}, // R6 no flush
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'h51, 5'd0, 8'h00, 1'b0}  // R6 data kept
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic fw, input logic [7:0] fd, input logic pu,
                         input logic [7:0] pd, input logic po);
        @(negedge clk);
        fcr_wr = fw; fcr_wdata = fd; push_valid = pu; push_data = pd; pop_req = po;
        #1;
    endtask

    task automatic idle_edge();
        @(posedge clk);
        #1;
        fcr_wr = 1'b0; push_valid = 1'b0; pop_req = 1'b0;
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "count", 32'(fill_count), 0);
        chk("R1", "empty", 32'(buf_empty), 1);
        chk("R1", "full", 32'(buf_full), 0);
        chk("R1", "fcr", 32'(fcr_q), 0);
        chk("R1", "overrun", 32'(overrun), 0);

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v].fw, VEC[v].fd, VEC[v].pu, VEC[v].pd, VEC[v].po);
            chk($sformatf("vec%0d", v), "pop_valid", 32'(pop_valid), 32'(VEC[v].epv));
            if (VEC[v].epv)
                chk($sformatf("vec%0d", v), "pop_data", 32'(pop_data), 32'(VEC[v].epd));
            idle_edge();
            chk($sformatf("vec%0d", v), "count", 32'(fill_count), 32'(VEC[v].ecnt));
            chk($sformatf("vec%0d", v), "fcr", 32'(fcr_q), 32'(VEC[v].efcr));
            chk($sformatf("vec%0d", v), "overrun", 32'(overrun), 32'(VEC[v].eovr));
        end

        // R10 fill sixteen entries in queued mode
        drive(1'b1, 8'h01, 1'b0, 8'h00, 1'b0);
        idle_edge();
        for (int i = 0; i < 16; i++) begin
            drive(1'b0, 8'h00, 1'b1, 8'(8'h60 + i), 1'b0);
            idle_edge();
        end
        chk("R10", "count full", 32'(fill_count), 16);
        chk("R10", "full flag", 32'(buf_full), 1);
        // R3 seventeenth byte dropped
        drive(1'b0, 8'h00, 1'b1, 8'h70, 1'b0);
        idle_edge();
        chk("R3", "overrun", 32'(overrun), 1);
        chk("R3", "count", 32'(fill_count), 16);
        // R10 partial drain then refill to wrap the pointers
        for (int i = 0; i < 5; i++) begin
            drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
            chk("R10", "order", 32'(pop_data), 32'(8'h60 + i));
            idle_edge();
        end
        for (int i = 0; i < 5; i++) begin
            drive(1'b0, 8'h00, 1'b1, 8'(8'h80 + i), 1'b0);
            idle_edge();
        end
        chk("R10", "count refill", 32'(fill_count), 16);
        for (int i = 0; i < 16; i++) begin
            drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
            chk("R10", "wrap order", 32'(pop_data),
                32'((i < 11) ? 8'(8'h65 + i) : 8'(8'h80 + i - 11)));
            idle_edge();
        end
        chk("R10", "empty after drain", 32'(buf_empty), 1);

        // R1 reset after use
        drive(1'b0, 8'h00, 1'b1, 8'hEE, 1'b0);
        idle_edge();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R1", "count after reset", 32'(fill_count), 0);
        chk("R1", "fcr after reset", 32'(fcr_q), 0);
        chk("R1", "empty after reset", 32'(buf_empty), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule